// File: doc/BRIEF.md
# Flash Program/Erase Suspend Controller

This block is the command interpreter that sits in front of a multi-plane flash array engine. It accepts one command per write strobe, together with a plane/sector address. It tracks whether an erase or a program is running, being suspended, or suspended. This includes a program issued while an erase is parked and then parked itself. Suspend and resume each have a single command code. The controller resolves what they mean from its current state. It applies a fixed suspend latency in clock cycles, and it publishes which planes are busy.

The array engine is modelled as two down-counters with parameterised operation times, one for erases and one for programs. An erase counter freezes while its erase is suspended and continues from where it stopped on resume. Commands arrive on a valid/ready port. A command is consumed on a rising clock edge where both `cmd_valid` and `cmd_ready` are high. The controller lowers `cmd_ready` only while a suspend request is draining, which takes `ERS_SPND_CYC` or `PRG_SPND_CYC` cycles. During that time the sender must hold the command stable. Status and busy outputs are plain level signals.

Top module: `flash_suspend_ctrl`

## Requirements
- R1: After reset, `cmd_ready` is 1, `plane_busy` is all zero, and `sts_erase_susp`, `sts_prog_susp` and `sts_seq_err` are 0.
- R2: A program (code 8'hB0) from idle sets exactly the `plane_busy` bit of its plane (address bits [7:3] with the default parameters; sector in bits [2:0]) for `PROG_CYC` cycles, then clears it.
- R3: Sector erase (8'hC0) and plane erase (8'hC1) keep their plane busy for `SECT_ERS_CYC` and `PLANE_ERS_CYC` cycles. Chip erase (8'hC2) sets every `plane_busy` bit for `CHIP_ERS_CYC` cycles.
- R4: Suspend (8'hD0) during a sector or plane erase lowers `cmd_ready` for `ERS_SPND_CYC` cycles, then raises `sts_erase_susp` and frees the plane. The erase time left is frozen and is used up after resume, so the total busy time still equals the erase time.
- R5: The same suspend code during a program lowers `cmd_ready` for `PRG_SPND_CYC` cycles, then raises `sts_prog_susp`. After resume (8'hD1) the remaining program time completes.
- R6: Suspend during a chip erase is ignored. There is no error, no stall and no suspended flag, and all planes stay busy.
- R7: Resume while an erase is suspended must carry the suspended plane in its address. With another plane it sets `sts_seq_err` and the erase stays suspended.
- R8: While an erase is suspended, a program to another sector is accepted and runs. A program to the suspended sector, or to any sector of a suspended plane erase, sets `sts_seq_err`.
- R9: Suspend during a program that was issued under erase suspend parks that program (both suspend flags high). Resume restarts it. When it completes, the controller returns to erase-suspended.
- R10: While a program is suspended, only read (8'hA0), status read (8'hA1), ID entry (8'hA2) and resume are legal. Status clear (8'hA3), program and erases set `sts_seq_err` and leave the state unchanged.
- R11: A read to a plane whose `plane_busy` bit is 0 is accepted without error in any state. A read to a busy plane sets `sts_seq_err`.
- R12: An illegal command, or any code outside the set {A0..A3, B0, C0..C2, D0, D1, E0, E1}, sets the sticky `sts_seq_err` and leaves the state and the running operation unchanged. A legal status clear (8'hA3) clears it.
- R13: If the operation being suspended finishes within the suspend latency, it completes. `cmd_ready` returns, and no suspended flag is ever raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe valid |
| cmd_ready | output | 1 | Controller can take a command (low during suspend latency) |
| cmd_code | input | 8 | Command code |
| cmd_addr | input | PLANE_W+SECT_W | {plane, sector} address |
| plane_busy | output | NUM_PLANES | One bit per plane with a running array operation |
| sts_erase_susp | output | 1 | An erase is suspended |
| sts_prog_susp | output | 1 | A program is suspended |
| sts_seq_err | output | 1 | Sticky command-sequence error |

## Verification
The bench accumulates busy cycles per plane across suspend and resume. A design that restarted, lost or double-counted erase time would miss the exact total. It issues a suspend a few cycles before a program ends. A controller that let the latency counter win would raise a suspended flag for an operation that no longer exists. The nested case checks the return to erase-suspended after the inner program completes, and that the shared codes are read per state. A design that applied the suspend to the erase, or resumed the erase by mistake, would show the wrong flag pair. It also checks that a suspend during a chip erase is ignored, and that a resume naming the wrong plane is rejected.

// File: rtl/flash_sc_pkg.sv
package flash_sc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ERASE,
    ST_ERASE_SPND_WAIT,
    ST_ERASE_SPND,
    ST_PROG,
    ST_PROG_SPND_WAIT,
    ST_PROG_SPND,
    ST_EPROG,
    ST_EPROG_SPND_WAIT,
    ST_EPROG_SPND
  } sc_state_t;

  typedef enum logic [1:0] {
    EK_SECTOR,
    EK_PLANE,
    EK_CHIP
  } ers_kind_t;

  localparam logic [7:0] OP_READ      = 8'hA0;
  localparam logic [7:0] OP_STAT_RD   = 8'hA1;
  localparam logic [7:0] OP_ID        = 8'hA2;
  localparam logic [7:0] OP_STAT_CLR  = 8'hA3;
  localparam logic [7:0] OP_PROG      = 8'hB0;
  localparam logic [7:0] OP_SECT_ERS  = 8'hC0;
  localparam logic [7:0] OP_PLANE_ERS = 8'hC1;
  localparam logic [7:0] OP_CHIP_ERS  = 8'hC2;
  localparam logic [7:0] OP_SUSPEND   = 8'hD0;
  localparam logic [7:0] OP_RESUME    = 8'hD1;
  localparam logic [7:0] OP_LOCK      = 8'hE0;
  localparam logic [7:0] OP_UNLOCK    = 8'hE1;

endpackage

// File: rtl/sc_op_timer.sv
module sc_op_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load,
  input  logic             run,
  output logic             done
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= load;
    end else if (run && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = run && (cnt == CNT_W'(1));

  // R4: remaining time is frozen whenever the operation is not running
  p_hold_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !run) |=> $stable(cnt));

  // R2: a started operation begins with its full duration
  p_load_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == $past(load)));

endmodule

// File: rtl/sc_cmd_decode.sv
module sc_cmd_decode
  import flash_sc_pkg::*;
#(
  parameter int NUM_PLANES = 32,
  parameter int PLANE_W    = 5,
  parameter int SECT_W     = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  sc_state_t             state,
  input  ers_kind_t             ers_kind,
  input  logic [PLANE_W-1:0]    ers_plane,
  input  logic [SECT_W-1:0]     ers_sect,
  input  logic [7:0]            code,
  input  logic [PLANE_W-1:0]    plane,
  input  logic [SECT_W-1:0]     sect,
  input  logic [NUM_PLANES-1:0] busy_mask,
  output logic                  legal,
  output logic                  ignore
);

  logic hit_suspended;
  logic prog_parked;

  assign hit_suspended = (plane == ers_plane) &&
                         (ers_kind == EK_PLANE || sect == ers_sect);
  assign prog_parked   = (state == ST_PROG_SPND) || (state == ST_EPROG_SPND);

  always_comb begin
    legal  = 1'b0;
    ignore = 1'b0;
    case (code)
      OP_STAT_RD, OP_ID: legal = 1'b1;
      OP_STAT_CLR:       legal = !prog_parked;
      OP_READ:           legal = !busy_mask[plane];
      OP_PROG:           legal = (state == ST_IDLE) ||
                                 (state == ST_ERASE_SPND && !hit_suspended);
      OP_SECT_ERS, OP_PLANE_ERS, OP_CHIP_ERS:
                         legal = (state == ST_IDLE);
      OP_SUSPEND: begin
        if (state == ST_ERASE) begin
          if (ers_kind == EK_CHIP) ignore = 1'b1;
          else                     legal  = 1'b1;
        end else begin
          legal = (state == ST_PROG) || (state == ST_EPROG);
        end
      end
      OP_RESUME:         legal = (state == ST_ERASE_SPND && plane == ers_plane) ||
                                 prog_parked;
      OP_LOCK, OP_UNLOCK:
                         legal = (state == ST_IDLE) || (state == ST_ERASE_SPND);
      default:           legal = 1'b0;
    endcase
  end

  // R6: a command is never both accepted and ignored
  p_legal_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(legal && ignore));

  // R8: the suspended sector cannot be programmed while its erase is parked
  p_no_prog_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERASE_SPND && code == OP_PROG && hit_suspended) |-> !legal);

endmodule

// File: rtl/flash_suspend_ctrl.sv
module flash_suspend_ctrl
  import flash_sc_pkg::*;
#(
  parameter int NUM_PLANES        = 32,
  parameter int SECTORS_PER_PLANE = 8,
  parameter int PROG_CYC          = 24,
  parameter int SECT_ERS_CYC      = 64,
  parameter int PLANE_ERS_CYC     = 96,
  parameter int CHIP_ERS_CYC      = 128,
  parameter int ERS_SPND_CYC      = 12,
  parameter int PRG_SPND_CYC      = 8,
  localparam int PLANE_W = $clog2(NUM_PLANES),
  localparam int SECT_W  = $clog2(SECTORS_PER_PLANE),
  localparam int ADDR_W  = PLANE_W + SECT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [7:0]            cmd_code,
  input  logic [ADDR_W-1:0]     cmd_addr,
  output logic [NUM_PLANES-1:0] plane_busy,
  output logic                  sts_erase_susp,
  output logic                  sts_prog_susp,
  output logic                  sts_seq_err
);

  localparam int ERS_MAX0 = (SECT_ERS_CYC > PLANE_ERS_CYC) ? SECT_ERS_CYC : PLANE_ERS_CYC;
  localparam int ERS_MAX  = (ERS_MAX0 > CHIP_ERS_CYC) ? ERS_MAX0 : CHIP_ERS_CYC;
  localparam int ECNT_W   = $clog2(ERS_MAX + 1);
  localparam int PCNT_W   = $clog2(PROG_CYC + 1);
  localparam int LAT_MAX  = (ERS_SPND_CYC > PRG_SPND_CYC) ? ERS_SPND_CYC : PRG_SPND_CYC;
  localparam int LAT_W    = $clog2(LAT_MAX + 1);

  sc_state_t          state, nxt_state;
  ers_kind_t          ers_kind;
  logic [PLANE_W-1:0] ers_plane, prg_plane, cmd_plane;
  logic [SECT_W-1:0]  ers_sect, cmd_sect;
  logic [LAT_W-1:0]   lat_cnt;
  logic               accept, legal, ignore, take;
  logic               ers_run, prg_run, ers_done, prg_done;
  logic               ers_start, prg_start, susp_take, in_wait;
  logic [ECNT_W-1:0]  ers_load;

  assign cmd_plane = cmd_addr[ADDR_W-1:SECT_W];
  assign cmd_sect  = cmd_addr[SECT_W-1:0];

  assign in_wait   = (state == ST_ERASE_SPND_WAIT) || (state == ST_PROG_SPND_WAIT) ||
                     (state == ST_EPROG_SPND_WAIT);
  assign cmd_ready = !in_wait;
  assign accept    = cmd_valid && cmd_ready;
  assign take      = accept && legal;

  assign ers_run = (state == ST_ERASE) || (state == ST_ERASE_SPND_WAIT);
  assign prg_run = (state == ST_PROG) || (state == ST_PROG_SPND_WAIT) ||
                   (state == ST_EPROG) || (state == ST_EPROG_SPND_WAIT);

  assign ers_start = take && (cmd_code == OP_SECT_ERS || cmd_code == OP_PLANE_ERS ||
                              cmd_code == OP_CHIP_ERS);
  assign prg_start = take && (cmd_code == OP_PROG);
  assign susp_take = take && (cmd_code == OP_SUSPEND);

  always_comb begin
    case (cmd_code)
      OP_SECT_ERS:  ers_load = ECNT_W'(SECT_ERS_CYC);
      OP_PLANE_ERS: ers_load = ECNT_W'(PLANE_ERS_CYC);
      default:      ers_load = ECNT_W'(CHIP_ERS_CYC);
    endcase
  end

  sc_cmd_decode #(
    .NUM_PLANES(NUM_PLANES),
    .PLANE_W   (PLANE_W),
    .SECT_W    (SECT_W)
  ) u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state),
    .ers_kind (ers_kind),
    .ers_plane(ers_plane),
    .ers_sect (ers_sect),
    .code     (cmd_code),
    .plane    (cmd_plane),
    .sect     (cmd_sect),
    .busy_mask(plane_busy),
    .legal    (legal),
    .ignore   (ignore)
  );

  sc_op_timer #(.CNT_W(ECNT_W)) u_ers_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(ers_start),
    .load (ers_load),
    .run  (ers_run),
    .done (ers_done)
  );

  sc_op_timer #(.CNT_W(PCNT_W)) u_prg_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(prg_start),
    .load (PCNT_W'(PROG_CYC)),
    .run  (prg_run),
    .done (prg_done)
  );

  // next-state: completion always wins over a pending suspend
  always_comb begin
    nxt_state = state;
    case (state)
      ST_IDLE: begin
        if (prg_start)      nxt_state = ST_PROG;
        else if (ers_start) nxt_state = ST_ERASE;
      end
      ST_ERASE: begin
        if (ers_done)       nxt_state = ST_IDLE;
        else if (susp_take) nxt_state = ST_ERASE_SPND_WAIT;
      end
      ST_ERASE_SPND_WAIT: begin
        if (ers_done)                   nxt_state = ST_IDLE;
        else if (lat_cnt == LAT_W'(1))  nxt_state = ST_ERASE_SPND;
      end
      ST_ERASE_SPND: begin
        if (prg_start)                               nxt_state = ST_EPROG;
        else if (take && cmd_code == OP_RESUME)      nxt_state = ST_ERASE;
      end
      ST_PROG: begin
        if (prg_done)       nxt_state = ST_IDLE;
        else if (susp_take) nxt_state = ST_PROG_SPND_WAIT;
      end
      ST_PROG_SPND_WAIT: begin
        if (prg_done)                   nxt_state = ST_IDLE;
        else if (lat_cnt == LAT_W'(1))  nxt_state = ST_PROG_SPND;
      end
      ST_PROG_SPND: begin
        if (take && cmd_code == OP_RESUME) nxt_state = ST_PROG;
      end
      ST_EPROG: begin
        if (prg_done)       nxt_state = ST_ERASE_SPND;
        else if (susp_take) nxt_state = ST_EPROG_SPND_WAIT;
      end
      ST_EPROG_SPND_WAIT: begin
        if (prg_done)                   nxt_state = ST_ERASE_SPND;
        else if (lat_cnt == LAT_W'(1))  nxt_state = ST_EPROG_SPND;
      end
      ST_EPROG_SPND: begin
        if (take && cmd_code == OP_RESUME) nxt_state = ST_EPROG;
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ers_kind  <= EK_SECTOR;
      ers_plane <= '0;
      ers_sect  <= '0;
      prg_plane <= '0;
      lat_cnt   <= '0;
      sts_seq_err <= 1'b0;
    end else begin
      state <= nxt_state;
      if (ers_start) begin
        ers_plane <= cmd_plane;
        ers_sect  <= cmd_sect;
        ers_kind  <= (cmd_code == OP_SECT_ERS)  ? EK_SECTOR :
                     (cmd_code == OP_PLANE_ERS) ? EK_PLANE : EK_CHIP;
      end
      if (prg_start) prg_plane <= cmd_plane;
      if (susp_take)
        lat_cnt <= (state == ST_ERASE) ? LAT_W'(ERS_SPND_CYC) : LAT_W'(PRG_SPND_CYC);
      else if (in_wait && lat_cnt != '0)
        lat_cnt <= lat_cnt - 1'b1;
      else
        lat_cnt <= '0;
      if (accept) begin
        if (legal && cmd_code == OP_STAT_CLR) sts_seq_err <= 1'b0;
        else if (!legal && !ignore)           sts_seq_err <= 1'b1;
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_PLANES; g++) begin : g_busy
      assign plane_busy[g] = (ers_run && (ers_kind == EK_CHIP || ers_plane == PLANE_W'(g))) ||
                             (prg_run && prg_plane == PLANE_W'(g));
    end
  endgenerate

  assign sts_erase_susp = (state == ST_ERASE_SPND) || (state == ST_EPROG) ||
                          (state == ST_EPROG_SPND_WAIT) || (state == ST_EPROG_SPND);
  assign sts_prog_susp  = (state == ST_PROG_SPND) || (state == ST_EPROG_SPND);

  // R4: the erase-suspended flag only appears after the latency wait
  p_esusp_after_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_erase_susp) |-> ($past(state) == ST_ERASE_SPND_WAIT));

  // R4: a parked erase with nothing else running frees every plane
  p_esusp_frees_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERASE_SPND) |-> (plane_busy == '0));

  // R2: a program occupies exactly one plane
  p_prog_one_plane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG || state == ST_PROG_SPND_WAIT) |-> ($countones(plane_busy) == 1));

  // R6: suspend during a chip erase neither stalls nor flags
  p_chip_susp_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_code == OP_SUSPEND && state == ST_ERASE && ers_kind == EK_CHIP)
    |=> (cmd_ready && !sts_erase_susp && $stable(sts_seq_err)));

  // R12: an illegal command sets the error and keeps the state
  p_illegal_keeps_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !legal && !ignore && !ers_done && !prg_done)
    |=> ($stable(state) && sts_seq_err));

  // R9: the nested program suspend always sits inside an erase suspend
  p_nested_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_EPROG_SPND) |-> (sts_erase_susp && sts_prog_susp));

endmodule

// File: tb/sim_flash_suspend_ctrl.sv
module sim_flash_suspend_ctrl;

  localparam int NP = 32;
  localparam int PROG_T = 24, SECT_T = 64, PLANE_T = 96, CHIP_T = 128;
  localparam int ESP_T = 12, PSP_T = 8;

  localparam logic [7:0] C_READ = 8'hA0, C_CLR = 8'hA3, C_PROG = 8'hB0;
  localparam logic [7:0] C_SERS = 8'hC0, C_PERS = 8'hC1, C_CERS = 8'hC2;
  localparam logic [7:0] C_SUSP = 8'hD0, C_RES = 8'hD1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [7:0]    cmd_code = 8'h00;
  logic [7:0]    cmd_addr = 8'h00;
  logic [NP-1:0] plane_busy;
  logic          sts_erase_susp, sts_prog_susp, sts_seq_err;

  int nchk = 0;
  int nerr = 0;
  int busy_acc = 0;
  int trk_plane = 0;
  bit trk = 1'b0;
  bit saw_psusp = 1'b0;

  always #2.5 clk = ~clk;

  flash_suspend_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .plane_busy(plane_busy),
    .sts_erase_susp(sts_erase_susp), .sts_prog_susp(sts_prog_susp),
    .sts_seq_err(sts_seq_err)
  );

  always @(negedge clk) begin
    if (trk && plane_busy[trk_plane]) busy_acc <= busy_acc + 1;
    if (sts_prog_susp) saw_psusp <= 1'b1;
  end

  function automatic logic [7:0] adr(input int p, input int s);
    return 8'((p << 3) | s);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  task automatic send(input logic [7:0] c, input logic [7:0] a);
    cmd_code = c; cmd_addr = a; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic ready_gap(output int n);
    n = 0;
    while (!cmd_ready) begin @(negedge clk); n++; end
  endtask

  task automatic wait_idle();
    while (plane_busy != '0) @(negedge clk);
  endtask

  task automatic track(input int p);
    @(negedge clk);
    busy_acc = 0; trk_plane = p; trk = 1'b1;
  endtask

  task automatic t_reset();
    check("R1 ready", cmd_ready, 1);
    check("R1 busy", plane_busy, 0);
    check("R1 flags", {sts_erase_susp, sts_prog_susp, sts_seq_err}, 0);
  endtask

  task automatic t_program();
    track(3);
    send(C_PROG, adr(3, 1));
    check("R2 single plane", plane_busy, 32'h1 << 3);
    wait_idle(); trk = 1'b0;
    check("R2 duration", busy_acc, PROG_T);
  endtask

  task automatic t_erases();
    track(5); send(C_SERS, adr(5, 2)); wait_idle(); trk = 1'b0;
    check("R3 sector time", busy_acc, SECT_T);
    track(6); send(C_PERS, adr(6, 0)); wait_idle(); trk = 1'b0;
    check("R3 plane time", busy_acc, PLANE_T);
    track(17); send(C_CERS, adr(0, 0));
    check("R3 chip all planes", plane_busy, {NP{1'b1}});
    wait_idle(); trk = 1'b0;
    check("R3 chip time", busy_acc, CHIP_T);
  endtask

  task automatic t_erase_suspend();
    int n;
    track(2);
    send(C_SERS, adr(2, 4));
    repeat (10) @(negedge clk);
    send(C_SUSP, 8'h00);
    ready_gap(n);
    check("R4 latency", n, ESP_T);
    check("R4 flag", sts_erase_susp, 1);
    check("R4 plane freed", plane_busy, 0);
    repeat (20) @(negedge clk);
    send(C_READ, adr(2, 4));
    check("R11 read suspended plane", sts_seq_err, 0);
    send(C_RES, adr(2, 0));
    check("R4 resumed", sts_erase_susp, 0);
    wait_idle(); trk = 1'b0;
    check("R4 total erase time", busy_acc, SECT_T);
  endtask

  task automatic t_wrong_resume();
    int n;
    send(C_SERS, adr(3, 0));
    repeat (5) @(negedge clk);
    send(C_SUSP, 8'h00); ready_gap(n);
    send(C_RES, adr(4, 0));
    check("R7 wrong plane error", sts_seq_err, 1);
    check("R7 still suspended", sts_erase_susp, 1);
    send(C_CLR, 8'h00);
    check("R12 clear", sts_seq_err, 0);
    send(C_RES, adr(3, 7));
    check("R7 right plane resumes", sts_erase_susp, 0);
    wait_idle();
  endtask

  task automatic t_prog_suspend();
    int n;
    track(1);
    send(C_PROG, adr(1, 2));
    repeat (6) @(negedge clk);
    send(C_SUSP, 8'h00);
    ready_gap(n);
    check("R5 latency", n, PSP_T);
    check("R5 flag", sts_prog_susp, 1);
    send(C_READ, adr(1, 2));
    check("R10 read legal", sts_seq_err, 0);
    send(C_CLR, 8'h00);
    check("R10 clear illegal", sts_seq_err, 1);
    send(C_SERS, adr(9, 0));
    check("R10 erase refused", plane_busy, 0);
    check("R10 state kept", sts_prog_susp, 1);
    send(C_RES, 8'h00);
    check("R5 resumed", sts_prog_susp, 0);
    wait_idle(); trk = 1'b0;
    check("R5 total program time", busy_acc, PROG_T);
    send(C_CLR, 8'h00);
  endtask

  task automatic t_chip_suspend();
    track(0);
    send(C_CERS, adr(0, 0));
    repeat (10) @(negedge clk);
    send(C_SUSP, 8'h00);
    check("R6 no stall", cmd_ready, 1);
    check("R6 no error", sts_seq_err, 0);
    check("R6 no flag", sts_erase_susp, 0);
    check("R6 still busy", plane_busy, {NP{1'b1}});
    wait_idle(); trk = 1'b0;
    check("R6 full chip time", busy_acc, CHIP_T);
  endtask

  task automatic t_nested();
    int n;
    track(2);
    send(C_SERS, adr(2, 4));
    repeat (4) @(negedge clk);
    send(C_SUSP, 8'h00); ready_gap(n);
    send(C_PROG, adr(2, 4));
    check("R8 same sector error", sts_seq_err, 1);
    check("R8 nothing started", plane_busy, 0);
    send(C_CLR, 8'h00);
    send(C_PROG, adr(2, 5));
    check("R8 other sector ok", sts_seq_err, 0);
    check("R8 program running", plane_busy, 32'h1 << 2);
    repeat (5) @(negedge clk);
    send(C_SUSP, 8'h00); ready_gap(n);
    check("R9 nested latency", n, PSP_T);
    check("R9 both flags", {sts_erase_susp, sts_prog_susp}, 2'b11);
    send(C_RES, 8'h00);
    check("R9 program restarted", {sts_erase_susp, sts_prog_susp, plane_busy[2]}, 3'b101);
    wait_idle();
    check("R9 back to erase-suspend", {sts_erase_susp, sts_prog_susp}, 2'b10);
    send(C_RES, adr(2, 0));
    wait_idle(); trk = 1'b0;
    check("R9 erase plus program time", busy_acc, SECT_T + PROG_T);
    send(C_PERS, adr(7, 0));
    repeat (3) @(negedge clk);
    send(C_SUSP, 8'h00); ready_gap(n);
    send(C_PROG, adr(7, 6));
    check("R8 plane erase conflict", sts_seq_err, 1);
    send(C_CLR, 8'h00);
    send(C_PROG, adr(8, 0));
    check("R8 other plane ok", sts_seq_err, 0);
    wait_idle();
    send(C_RES, adr(7, 0));
    wait_idle();
  endtask

  task automatic t_busy_read();
    send(C_PROG, adr(4, 0));
    send(C_READ, adr(4, 1));
    check("R11 busy plane read", sts_seq_err, 1);
    send(C_CLR, 8'h00);
    send(C_READ, adr(9, 1));
    check("R11 idle plane read", sts_seq_err, 0);
    wait_idle();
  endtask

  task automatic t_illegal();
    send(8'h55, 8'h00);
    check("R12 unknown code", sts_seq_err, 1);
    check("R12 nothing started", plane_busy, 0);
    send(C_CLR, 8'h00);
    send(C_RES, 8'h00);
    check("R12 resume when idle", sts_seq_err, 1);
    send(C_CLR, 8'h00);
    track(6);
    send(C_SERS, adr(6, 0));
    send(C_PROG, adr(6, 3));
    check("R12 program during erase", sts_seq_err, 1);
    wait_idle(); trk = 1'b0;
    check("R12 erase unaffected", busy_acc, SECT_T);
    send(C_CLR, 8'h00);
  endtask

  task automatic t_done_in_latency();
    int n;
    track(0);
    send(C_PROG, adr(0, 0));
    repeat (19) @(negedge clk);
    saw_psusp = 1'b0;
    send(C_SUSP, 8'h00);
    ready_gap(n);
    check("R13 no flag seen", saw_psusp, 0);
    check("R13 completed", plane_busy, 0);
    check("R13 no error", sts_seq_err, 0);
    trk = 1'b0;
    check("R13 program time", busy_acc, PROG_T);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_erases();
    t_erase_suspend();
    t_wrong_resume();
    t_prog_suspend();
    t_chip_suspend();
    t_nested();
    t_busy_read();
    t_illegal();
    t_done_in_latency();
    finish_run();
  end

endmodule